// File: doc/BRIEF.md
# Display Pixel Buffer Refill Controller

This block holds pixel words between a memory-fetch port and a display output that drains them at a steady rate. It keeps a fill count and asks the memory side for fixed-length bursts. Two programmable thresholds form a hysteresis window. Refill starts once the fill level falls to the lower mark. It continues until the level plus the beats still in flight reach the upper mark. Between refills, a standby output tells the memory path that it may idle.

The storage is split into equal banks. In the normal mode the pipeline uses one bank. In merged mode it uses all banks as one deeper buffer. Before the display starts reading, an initial fill runs up to either the lower or the upper mark, as chosen by a select input. A done flag reports when that fill is complete. If the display reads while nothing is stored, a sticky underflow flag is raised. That flag is cleared by a one-cycle clear pulse. Mode and thresholds are captured only while the output is disabled. Disabling the output empties the buffer.

Top module: `disp_refill_ctrl`

## Requirements
- R1: The active depth D is BANK_DEPTH when merge_en was low at capture, and NUM_BANKS*BANK_DEPTH when it was high. The `level` output counts stored beats and never exceeds D.
- R2: After the initial fill, a refill flag is set on any cycle with level <= low. It is cleared on a cycle with level > low and projected >= high. Requests are made while (flag or level <= low) and projected < high.
- R3: Captured thresholds are clamped. The high mark becomes min(high_thr_in, D-1), raised to at least 1. The low mark is lowered to high-1 if it is not below the high mark. After reset, before any capture, D = BANK_DEPTH, high = D-1 and low = D-BURST_LEN.
- R4: Each accepted request (req_valid and req_ready) adds BURST_LEN beats to the outstanding count. projected = level + outstanding. req_valid is only asserted if projected + BURST_LEN <= D.
- R5: mstandby is high exactly when no beats are outstanding and the block is not (enabled and either still in the initial fill or in refill). It is high while out_en is low.
- R6: While the initial fill is running, requests are made while projected < target. The target is the high mark when preload_hi is 1 and the low mark when it is 0. prefill_done rises the cycle after level >= target.
- R7: A pix_rd that is not served (buffer empty or output disabled) sets `underflow` on the next cycle. The flag stays set until a cycle with uf_clr high and no new unserved read. pix_data keeps its last value.
- R8: Mode and thresholds are captured only on cycles with out_en low, so changing them while enabled has no effect. A cycle with out_en low clears the level, the outstanding beats, the refill flag and prefill_done by the next cycle.
- R9: A served pix_rd presents the oldest stored beat on pix_data in the following cycle, in arrival order.
- R10: A fill_valid beat that arrives while no beats are outstanding is dropped and leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Output enable; low flushes and opens configuration capture |
| merge_en | input | 1 | Merged-bank mode request |
| low_thr_in | input | CNT_W | Requested low mark |
| high_thr_in | input | CNT_W | Requested high mark |
| preload_hi | input | 1 | Initial fill target: 1 = high mark, 0 = low mark |
| req_valid | output | 1 | Burst fetch request |
| req_ready | input | 1 | Memory side accepts the request |
| fill_valid | input | 1 | Returned data beat |
| fill_data | input | DATA_W | Returned beat value |
| pix_rd | input | 1 | Display pulls one beat |
| pix_data | output | DATA_W | Beat delivered to the display |
| prefill_done | output | 1 | Initial fill complete |
| mstandby | output | 1 | Memory path may idle |
| underflow | output | 1 | Sticky empty-read flag |
| uf_clr | input | 1 | Clear pulse for underflow |
| level | output | CNT_W | Stored beat count |

## Verification
The assertions assume that the memory side returns exactly the beats it was granted, one per cycle at most, and in order. They also assume that the display never needs data it has not waited for. The bench acts as the memory model and returns data only while its own count of owed beats is non-zero. It does inject stray fill beats on purpose, and the block is required to drop them. Display reads are held back until prefill_done, except in the phases that aim at underflow. Threshold inputs are randomised only while the output is enabled, or while it is being captured deliberately.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  // usable depth for the selected bank arrangement
  function automatic int unsigned active_depth(input bit merged, input int unsigned bank,
                                               input int unsigned banks);
    return merged ? bank * banks : bank;
  endfunction

  // upper mark limited to [1, d-1]
  function automatic int unsigned clamp_high(input int unsigned hi, input int unsigned d);
    int unsigned h;
    h = (hi > d - 1) ? d - 1 : hi;
    if (h == 0) h = 1;
    return h;
  endfunction

  // lower mark kept strictly under the upper mark
  function automatic int unsigned clamp_low(input int unsigned lo, input int unsigned h);
    return (lo >= h) ? h - 1 : lo;
  endfunction

  function automatic int unsigned default_low(input int unsigned d, input int unsigned burst);
    return d - burst;
  endfunction

  function automatic int unsigned default_high(input int unsigned d);
    return d - 1;
  endfunction

  // a whole burst still fits after everything already counted
  function automatic bit has_room(input int unsigned proj, input int unsigned burst,
                                  input int unsigned d);
    return (proj + burst) <= d;
  endfunction

endpackage

// File: rtl/dfr_store.sv
module dfr_store #(
  parameter int DATA_W     = 32,
  parameter int BANK_DEPTH = 256,
  parameter int NUM_BANKS  = 3,
  parameter int CNT_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [CNT_W-1:0]  depth,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH_MAX = BANK_DEPTH * NUM_BANKS;
  localparam int PTR_W     = $clog2(DEPTH_MAX);
  localparam int OFF_W     = $clog2(BANK_DEPTH);
  localparam int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [SEL_W-1:0] wr_bank, rd_bank, sel_q;
  logic [OFF_W-1:0] wr_off, rd_off;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                input logic [CNT_W-1:0] d);
    return (CNT_W'(p) == d - CNT_W'(1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign wr_bank = SEL_W'(wr_ptr / PTR_W'(BANK_DEPTH));
  assign rd_bank = SEL_W'(rd_ptr / PTR_W'(BANK_DEPTH));
  assign wr_off  = OFF_W'(wr_ptr % PTR_W'(BANK_DEPTH));
  assign rd_off  = OFF_W'(rd_ptr % PTR_W'(BANK_DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      sel_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= step_ptr(wr_ptr, depth);
      if (rd_en) begin
        rd_ptr <= step_ptr(rd_ptr, depth);
        sel_q  <= rd_bank;
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [BANK_DEPTH];
    logic [DATA_W-1:0] rq;
    always_ff @(posedge clk) begin
      if (wr_en && !flush && wr_bank == SEL_W'(b)) mem[wr_off] <= wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rq <= '0;
      else if (rd_en && !flush && rd_bank == SEL_W'(b)) rq <= mem[rd_off];
    end
    assign bank_q[b] = rq;
  end

  assign rd_data = bank_q[sel_q];

endmodule

// File: rtl/dfr_level.sv
module dfr_level #(
  parameter int BURST_LEN = 16,
  parameter int CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [CNT_W-1:0] depth,
  input  logic             fill_valid,
  input  logic             pix_rd,
  input  logic             burst_acc,
  output logic [CNT_W-1:0] level,
  output logic [CNT_W-1:0] outst,
  output logic [CNT_W:0]   proj,
  output logic             push,
  output logic             pop
);
  // beats are only taken while some are owed; reads only while something is stored
  assign push = fill_valid && (outst != '0) && !flush;
  assign pop  = pix_rd && (level != '0) && !flush;
  assign proj = {1'b0, level} + {1'b0, outst};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      outst <= '0;
    end else if (flush) begin
      level <= '0;
      outst <= '0;
    end else begin
      level <= level + CNT_W'(push) - CNT_W'(pop);
      outst <= outst + (burst_acc ? CNT_W'(BURST_LEN) : '0) - CNT_W'(push);
    end
  end

  a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= depth);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    proj <= {1'b0, depth});
  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0) && (outst == '0));

endmodule

// File: rtl/dfr_refill.sv
module dfr_refill #(
  parameter int BURST_LEN = 16,
  parameter int CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_en,
  input  logic             preload_hi,
  input  logic [CNT_W-1:0] depth,
  input  logic [CNT_W-1:0] low_thr,
  input  logic [CNT_W-1:0] high_thr,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W:0]   proj,
  input  logic             inflight,
  output logic             req_valid,
  output logic             mstandby,
  output logic             prefill_done
);
  logic             refill_q, preloaded_q;
  logic             below_low, refill_act, want, room;
  logic [CNT_W-1:0] target;

  assign below_low  = level <= low_thr;
  assign refill_act = refill_q || below_low;
  assign target     = preload_hi ? high_thr : low_thr;
  assign room       = dfr_pkg::has_room(32'(proj), BURST_LEN, 32'(depth));
  assign want       = !preloaded_q ? (proj < {1'b0, target})
                                   : (refill_act && proj < {1'b0, high_thr});
  assign req_valid  = out_en && want && room;
  assign mstandby   = !inflight && !(out_en && (!preloaded_q || refill_act));
  assign prefill_done = preloaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refill_q    <= 1'b0;
      preloaded_q <= 1'b0;
    end else if (!out_en) begin
      refill_q    <= 1'b0;
      preloaded_q <= 1'b0;
    end else begin
      if (below_low)                    refill_q <= 1'b1;
      else if (proj >= {1'b0, high_thr}) refill_q <= 1'b0;
      if (level >= target) preloaded_q <= 1'b1;
    end
  end

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    mstandby |-> !req_valid);
  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !prefill_done);

endmodule

// File: rtl/disp_refill_ctrl.sv
module disp_refill_ctrl #(
  parameter  int DATA_W     = 32,
  parameter  int BANK_DEPTH = 256,
  parameter  int NUM_BANKS  = 3,
  parameter  int BURST_LEN  = 16,
  localparam int DEPTH_MAX  = BANK_DEPTH * NUM_BANKS,
  localparam int CNT_W      = $clog2(DEPTH_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_en,
  input  logic              merge_en,
  input  logic [CNT_W-1:0]  low_thr_in,
  input  logic [CNT_W-1:0]  high_thr_in,
  input  logic              preload_hi,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              pix_rd,
  output logic [DATA_W-1:0] pix_data,
  output logic              prefill_done,
  output logic              mstandby,
  output logic              underflow,
  input  logic              uf_clr,
  output logic [CNT_W-1:0]  level
);
  logic [CNT_W-1:0] cfg_depth, cfg_low, cfg_high;
  logic [CNT_W-1:0] d_in, hi_c, lo_c;
  logic [CNT_W-1:0] outst;
  logic [CNT_W:0]   proj;
  logic             push, pop, burst_acc, empty_rd;

  // capture window: only while the output is off
  assign d_in = CNT_W'(dfr_pkg::active_depth(merge_en, BANK_DEPTH, NUM_BANKS));
  assign hi_c = CNT_W'(dfr_pkg::clamp_high(32'(high_thr_in), 32'(d_in)));
  assign lo_c = CNT_W'(dfr_pkg::clamp_low(32'(low_thr_in), 32'(hi_c)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_depth <= CNT_W'(BANK_DEPTH);
      cfg_high  <= CNT_W'(dfr_pkg::default_high(BANK_DEPTH));
      cfg_low   <= CNT_W'(dfr_pkg::default_low(BANK_DEPTH, BURST_LEN));
    end else if (!out_en) begin
      cfg_depth <= d_in;
      cfg_high  <= hi_c;
      cfg_low   <= lo_c;
    end
  end

  assign burst_acc = req_valid && req_ready;
  assign empty_rd  = pix_rd && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underflow <= 1'b0;
    else        underflow <= empty_rd || (underflow && !uf_clr);
  end

  dfr_level #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_level (
    .clk(clk), .rst_n(rst_n), .flush(!out_en), .depth(cfg_depth),
    .fill_valid(fill_valid), .pix_rd(pix_rd), .burst_acc(burst_acc),
    .level(level), .outst(outst), .proj(proj), .push(push), .pop(pop)
  );

  dfr_refill #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_refill (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .preload_hi(preload_hi),
    .depth(cfg_depth), .low_thr(cfg_low), .high_thr(cfg_high),
    .level(level), .proj(proj), .inflight(outst != '0),
    .req_valid(req_valid), .mstandby(mstandby), .prefill_done(prefill_done)
  );

  dfr_store #(.DATA_W(DATA_W), .BANK_DEPTH(BANK_DEPTH), .NUM_BANKS(NUM_BANKS),
              .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(!out_en), .depth(cfg_depth),
    .wr_en(push), .wr_data(fill_data), .rd_en(pop), .rd_data(pix_data)
  );

  a_r5_above_low: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && mstandby) |-> level > cfg_low);
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_rd && level == '0) |=> underflow);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !uf_clr) |=> underflow);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> $stable(pix_data));

endmodule

// File: tb/tb_disp_refill_ctrl.sv
module tb_disp_refill_ctrl;
  localparam int BANK = 256, NB = 3, B = 16, W = 10;

  logic clk = 0, rst_n = 0;
  logic out_en = 0, merge_en = 0, preload_hi = 1, req_ready = 0, fill_valid = 0;
  logic pix_rd = 0, uf_clr = 0;
  logic [W-1:0] low_thr_in = 0, high_thr_in = 0;
  logic [31:0] fill_data = 0;
  logic req_valid, prefill_done, mstandby, underflow;
  logic [31:0] pix_data;
  logic [W-1:0] level;

  always #5 clk = ~clk;

  disp_refill_ctrl dut (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .merge_en(merge_en),
    .low_thr_in(low_thr_in), .high_thr_in(high_thr_in), .preload_hi(preload_hi),
    .req_valid(req_valid), .req_ready(req_ready), .fill_valid(fill_valid),
    .fill_data(fill_data), .pix_rd(pix_rd), .pix_data(pix_data),
    .prefill_done(prefill_done), .mstandby(mstandby), .underflow(underflow),
    .uf_clr(uf_clr), .level(level)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  int lvl = 0, ost = 0, cd = BANK, cl = BANK - B, ch = BANK - 1;
  bit rf = 0, pre = 0, uf = 0;
  logic [31:0] pix_m = 0;
  logic [31:0] q[$];

  // stimulus knobs
  bit k_en = 0, k_mrg = 0, k_phi = 1, k_anyrd = 0, k_clr = 0, k_wig = 0;
  int k_lo = BANK - B, k_hi = BANK - 1, k_rd = 0, k_rdy = 0, k_fill = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void bclamp(input int lo_i, input int hi_i, input int d,
                                 output int lo_o, output int hi_o);
    hi_o = (hi_i <= d - 1) ? hi_i : d - 1;
    if (hi_o < 1) hi_o = 1;
    lo_o = (lo_i < hi_o) ? lo_i : hi_o - 1;
  endfunction

  // level reached with no reads: bursts until the mark is met, capped by depth
  function automatic int settle(input int hi, input int d);
    int s = ((hi + B - 1) / B) * B;
    return (s > d) ? d : s;
  endfunction

  task automatic step();
    int pm, tgt, lvl0, dn, lo_n, hi_n;
    bit ract, want, room, ereq, estb, acc, fl, pp;
    out_en = k_en; merge_en = k_mrg; preload_hi = k_phi; uf_clr = k_clr;
    if (k_wig) begin
      low_thr_in  = W'($urandom_range(1023));
      high_thr_in = W'($urandom_range(1023));
    end else begin
      low_thr_in = W'(k_lo); high_thr_in = W'(k_hi);
    end
    pix_rd     = ($urandom_range(99) < k_rd) && (prefill_done || k_anyrd) && k_en;
    req_ready  = $urandom_range(99) < k_rdy;
    fill_valid = $urandom_range(99) < k_fill;
    fill_data  = $urandom;
    #1;
    pm = lvl + ost;
    ract = rf || (lvl <= cl);
    tgt = k_phi ? ch : cl;
    want = !pre ? (pm < tgt) : (ract && pm < ch);
    room = (pm + B) <= cd;
    ereq = k_en && want && room;
    estb = (ost == 0) && !(k_en && (!pre || ract));
    chk(level == W'(lvl), "R1 level", int'(level), lvl);
    chk(req_valid == ereq, "R2 req_valid", int'(req_valid), int'(ereq));
    if (req_valid) chk(pm + B <= cd, "R4 room", pm + B, cd);
    chk(mstandby == estb, "R5 mstandby", int'(mstandby), int'(estb));
    chk(prefill_done == pre, "R6 prefill_done", int'(prefill_done), int'(pre));
    chk(underflow == uf, "R7 underflow", int'(underflow), int'(uf));
    chk(pix_data === pix_m, "R9 pix_data", int'(pix_data), int'(pix_m));
    // advance the reference as the edge will
    lvl0 = lvl;
    pp = k_en && pix_rd && lvl > 0;
    if (!k_en) begin
      lvl = 0; ost = 0; rf = 0; pre = 0; q.delete();
      dn = k_mrg ? BANK * NB : BANK;
      bclamp(int'(low_thr_in), int'(high_thr_in), dn, lo_n, hi_n);
      cd = dn; cl = lo_n; ch = hi_n;
    end else begin
      acc = ereq && req_ready;
      fl = fill_valid && ost > 0;
      if (pp) pix_m = q.pop_front();
      if (fl) q.push_back(fill_data);
      if (lvl <= cl) rf = 1; else if (pm >= ch) rf = 0;
      if (lvl >= tgt) pre = 1;
      lvl = lvl + int'(fl) - int'(pp);
      ost = ost + (acc ? B : 0) - int'(fl);
    end
    uf = (pix_rd && !pp) || (uf && !k_clr);
    if (lvl0 < 0) uf = uf;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_pre();
    for (int i = 0; i < 3000 && !prefill_done; i++) step();
  endtask

  task automatic reconfig(input bit m, input int lo, input int hi, input bit phi);
    k_en = 0; k_wig = 0; k_mrg = m; k_lo = lo; k_hi = hi; k_phi = phi;
    run(3);
    chk(level == 0, "R8 flush", int'(level), 0);
    k_en = 1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk(level == 0, "R1 reset level", int'(level), 0);
    chk(mstandby == 1, "R5 reset standby", int'(mstandby), 1);
    chk(req_valid == 0, "R4 reset req", int'(req_valid), 0);
    chk(underflow == 0, "R7 reset underflow", int'(underflow), 0);
    chk(prefill_done == 0, "R6 reset prefill", int'(prefill_done), 0);
    @(negedge clk);

    // single bank, default marks (R3 defaults), upper-mark preload
    k_rd = 30; k_rdy = 70; k_fill = 60;
    reconfig(0, BANK - B, BANK - 1, 1);
    run(3000);

    // merged, upper mark clamped to D-1, lower-mark preload
    k_rd = 50; k_rdy = 80; k_fill = 70;
    reconfig(1, 240, 1023, 0);
    run(3000);

    // merged window with thresholds wiggled while enabled (R8: no effect)
    k_rd = 40; k_rdy = 60; k_fill = 80;
    reconfig(1, 400, 600, 1);
    k_wig = 1; run(3000); k_wig = 0;

    // R6: lower-mark preload stops short of the upper mark
    k_rd = 0; k_rdy = 100; k_fill = 100;
    reconfig(1, 400, 600, 0);
    wait_pre();
    chk(prefill_done && level >= 400 && level < 600, "R6 preload to low", int'(level), 400);

    // R3: inverted marks in single bank -> high 100, low 99
    reconfig(0, 300, 100, 1);
    run(400);
    chk(level == W'(settle(100, BANK)), "R3 clamp single", int'(level), settle(100, BANK));
    // R3: both marks above depth in merged mode -> high 767
    reconfig(1, 900, 900, 1);
    run(1200);
    chk(level == W'(settle(BANK * NB - 1, BANK * NB)), "R3 clamp merged",
        int'(level), settle(BANK * NB - 1, BANK * NB));

    // R10: stray beats with nothing owed
    k_rdy = 0; k_fill = 100;
    reconfig(0, 240, 255, 1);
    run(20);
    chk(level == 0, "R10 stray fill dropped", int'(level), 0);

    // R7: drain to empty with memory stalled
    k_rdy = 100; wait_pre();
    k_rdy = 0; k_rd = 100; k_anyrd = 1;
    run(400);
    chk(underflow == 1, "R7 underflow set", int'(underflow), 1);
    k_rd = 0; run(3);
    chk(underflow == 1, "R7 sticky", int'(underflow), 1);
    k_clr = 1; run(1); k_clr = 0; run(1);
    chk(underflow == 0, "R7 cleared", int'(underflow), 0);
    k_rd = 100; run(2);
    chk(underflow == 1, "R7 set again", int'(underflow), 1);
    k_clr = 1; run(1); k_clr = 0; k_rd = 0; k_anyrd = 0; run(2);

    // random configurations
    for (int s = 0; s < 4; s++) begin
      k_rd = $urandom_range(20, 60); k_rdy = $urandom_range(30, 100);
      k_fill = $urandom_range(40, 100);
      reconfig(s[0], $urandom_range(1023), $urandom_range(1023), s[1]);
      run(1500);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule